// File: doc/BRIEF.md
# Debounced Input-Port Interrupt Unit

This block watches an eight-pin input port split into two groups of four pins. Every pin passes through a two-flop synchronizer and then a chattering filter. Each group has its own check-time setting. The check time comes from divider taps of a slow tick and a fast tick, both supplied as single-cycle enable pulses in the system clock domain.

Each filtered level is compared against that pin's bit in a comparison register. When a mismatch first appears, the pin's interrupt flag latches. An enabled flag drives the single interrupt request. Software uses a small register bus to program the check times, the reference levels and the enables, and to clear flags by writing ones.

Top module: `dbnc_port_irq`

## Requirements
- R1: After reset, the check-time register (address 0) reads 0x00, the comparison register (address 1) reads 0xFF, the enable register (address 2) reads 0x00, the flag register (address 3) reads 0x00, and irq_o is 0. Read data is combinational on reg_addr_i.
- R2: The check-time register holds code bits [2:0] for pins 0-3 and code bits [6:4] for pins 4-7. Code 0 disables filtering, so the filtered level tracks the synchronized pin each cycle.
- R3: In the codes, 1, 2 and 3 select 1, 2 and 4 fast ticks, and 4, 5, 6 and 7 select 128, 512, 2048 and 4096 slow ticks. The filtered level changes only on a tick of the selected tap.
- R4: A pin level that lasts no longer than one check time is rejected. A level that lasts at least two check times is accepted.
- R5: The two groups filter independently, each under its own code.
- R6: A flag bit sets in the cycle after its filtered level first differs from its comparison bit. A mismatch that persists does not set it again.
- R7: Writing 1 to a bit at address 3 clears that flag. Writing 0 leaves it unchanged. A new set wins over a clear in the same cycle.
- R8: irq_o is 1 exactly when some bit is set in both the flag register and the enable register (address 2).
- R9: The comparison register sets the reference level per pin. A pin that matches its reference raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Raw asynchronous pin levels |
| slow_tick_i | input | 1 | Single-cycle pulse per slow-clock period |
| fast_tick_i | input | 1 | Single-cycle pulse per fast-clock period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a pulse placed exactly at the rejection and acceptance boundaries. The divider phase is hidden, so the pin must be held for an exact count of selected ticks. The bench changes pins only between uniformly spaced tick pulses and follows every pulse with further ticks. This way a hold of exactly one check time spans exactly one tap event, whatever the divider phase. A hold just over two check times spans at least two tap events. Group independence is tested by giving the same glitch to both groups while they run different codes.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_CMP  = 2'd1,
    A_EN   = 2'd2,
    A_FLAG = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    CT_NONE = 3'd0,
    CT_F1   = 3'd1,
    CT_F2   = 3'd2,
    CT_F4   = 3'd3,
    CT_S128 = 3'd4,
    CT_S512 = 3'd5,
    CT_S2K  = 3'd6,
    CT_S4K  = 3'd7
  } ct_e;

  localparam int unsigned CT_FIELD_W = 4;
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '1;
      s1_q <= '1;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/dbnc_prescaler.sv
module dbnc_prescaler #(
  parameter int unsigned CNT_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  output logic [CNT_W:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // tap k pulses once every 2**k ticks
  assign tap_o[0] = tick_i;
  for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
    assign tap_o[k] = tick_i & (&cnt_q[k-1:0]);
  end
endmodule

// File: rtl/dbnc_group.sv
module dbnc_group #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         bypass_i,
  input  logic         tick_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] flt_o
);
  logic [W-1:0] sync_w;

  dbnc_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic smp_q, flt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q <= 1'b1;
        flt_q <= 1'b1;
      end else if (bypass_i) begin
        smp_q <= sync_w[i];
        flt_q <= sync_w[i];
      end else if (tick_i) begin
        smp_q <= sync_w[i];
        // accept only when two consecutive samples agree
        if (smp_q == sync_w[i]) flt_q <= sync_w[i];
      end
    end
    assign flt_o[i] = flt_q;
  end

  assign sync_o = sync_w;
endmodule

// File: rtl/dbnc_port_irq.sv
module dbnc_port_irq #(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned GRP    = 4,
  parameter int unsigned SLOW_W = 12,
  parameter int unsigned FAST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pins_i,
  input  logic            slow_tick_i,
  input  logic            fast_tick_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [NPIN-1:0] reg_wdata_i,
  output logic [NPIN-1:0] reg_rdata_o,
  output logic            irq_o
);
  import dbnc_pkg::*;

  localparam int unsigned NGRP = NPIN / GRP;

  logic [SLOW_W:0]     slow_tap;
  logic [FAST_W:0]     fast_tap;
  ct_e                 ctl_q [NGRP];
  logic [NPIN-1:0]     cmp_q, en_q, flag_q, mis_q;
  logic [NPIN-1:0]     sync_w, flt_w, mis_w, set_w, w1c_mask;
  logic [NGRP-1:0]     grp_tick, grp_byp;
  logic [NPIN-1:0]     ctl_rd;

  dbnc_prescaler #(.CNT_W(SLOW_W)) u_slow (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(slow_tick_i), .tap_o(slow_tap)
  );
  dbnc_prescaler #(.CNT_W(FAST_W)) u_fast (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(fast_tick_i), .tap_o(fast_tap)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_byp[g]  = 1'b0;
      grp_tick[g] = 1'b0;
      unique case (ctl_q[g])
        CT_NONE: grp_byp[g]  = 1'b1;
        CT_F1:   grp_tick[g] = fast_tap[0];
        CT_F2:   grp_tick[g] = fast_tap[1];
        CT_F4:   grp_tick[g] = fast_tap[2];
        CT_S128: grp_tick[g] = slow_tap[7];
        CT_S512: grp_tick[g] = slow_tap[9];
        CT_S2K:  grp_tick[g] = slow_tap[11];
        CT_S4K:  grp_tick[g] = slow_tap[12];
        default: grp_byp[g]  = 1'b1;
      endcase
    end

    dbnc_group #(.W(GRP)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pins_i[g*GRP +: GRP]),
      .bypass_i(grp_byp[g]),
      .tick_i  (grp_tick[g]),
      .sync_o  (sync_w[g*GRP +: GRP]),
      .flt_o   (flt_w[g*GRP +: GRP])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_q[g] <= CT_NONE;
      else if (reg_wr_i && reg_addr_i == A_CTL)
        ctl_q[g] <= ct_e'(reg_wdata_i[g*CT_FIELD_W +: 3]);
    end

    assign ctl_rd[g*CT_FIELD_W +: CT_FIELD_W] = {1'b0, ctl_q[g]};
  end

  assign mis_w    = flt_w ^ cmp_q;
  assign set_w    = mis_w & ~mis_q;
  assign w1c_mask = (reg_wr_i && reg_addr_i == A_FLAG) ? reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      en_q   <= '0;
      flag_q <= '0;
      mis_q  <= '0;
    end else begin
      mis_q  <= mis_w;
      flag_q <= (flag_q & ~w1c_mask) | set_w;
      if (reg_wr_i && reg_addr_i == A_CMP) cmp_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_EN)  en_q  <= reg_wdata_i;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      A_CTL:   reg_rdata_o = ctl_rd;
      A_CMP:   reg_rdata_o = cmp_q;
      A_EN:    reg_rdata_o = en_q;
      default: reg_rdata_o = flag_q;
    endcase
  end

  assign irq_o = |(flag_q & en_q);
endmodule

// File: rtl/dbnc_port_irq_chk.sv
module dbnc_port_irq_chk #(
  parameter int unsigned NPIN = 8,
  parameter int unsigned GRP  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic [NPIN/GRP-1:0] grp_tick,
  input logic [NPIN/GRP-1:0] grp_byp,
  input logic [NPIN-1:0] sync_w,
  input logic [NPIN-1:0] flt_w,
  input logic [NPIN-1:0] mis_q,
  input logic [NPIN-1:0] flag_q,
  input logic [NPIN-1:0] en_q,
  input logic [NPIN-1:0] w1c_mask
);
  for (genvar g = 0; g < NPIN / GRP; g++) begin : g_chk
    a_r2_bypass_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_byp[g] |=> flt_w[g*GRP +: GRP] == $past(sync_w[g*GRP +: GRP]));
    a_r3_moves_on_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(flt_w[g*GRP +: GRP]) |-> $past(grp_tick[g] | grp_byp[g]));
  end

  a_r6_set_needs_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~mis_q) == '0));

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(flag_q & ~w1c_mask)) == $past(flag_q & ~w1c_mask)));

  a_r8_no_irq_unenabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == '0) |-> !irq_o);
endmodule

bind dbnc_port_irq dbnc_port_irq_chk #(.NPIN(NPIN), .GRP(GRP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .grp_tick(grp_tick),
  .grp_byp (grp_byp),
  .sync_w  (sync_w),
  .flt_w   (flt_w),
  .mis_q   (mis_q),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .w1c_mask(w1c_mask)
);

// File: tb/tb_dbnc_port_irq.sv
module tb_dbnc_port_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic       slow_tick = 1'b0, fast_tick = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dbnc_port_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .slow_tick_i(slow_tick), .fast_tick_i(fast_tick),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // uniformly spaced ticks: 1 cycle pulse, 3 idle
  task automatic ticks(input bit slow, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
      idle(2);
    end
  endtask

  task automatic restore();
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd1, 8'hFF);
    @(negedge clk); pins = 8'hFF;
    idle(8);
    wr_reg(2'd3, 8'hFF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(2'd0, d); chk("R1 ctl reset", d, 8'h00);
    rd_reg(2'd1, d); chk("R1 cmp reset", d, 8'hFF);
    rd_reg(2'd2, d); chk("R1 en reset", d, 8'h00);
    rd_reg(2'd3, d); chk("R1 flag reset", d, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_bypass_flag_irq();
    logic [7:0] d;
    @(negedge clk); pins = 8'hFE;
    idle(6);
    rd_reg(2'd3, d); chk("R2 R6 bypass mismatch flag", d, 8'h01);
    chk("R8 irq gated off", {7'd0, irq}, 8'h00);
    wr_reg(2'd2, 8'h02);
    #1 chk("R8 other enable bit", {7'd0, irq}, 8'h00);
    wr_reg(2'd2, 8'h01);
    #1 chk("R8 irq on", {7'd0, irq}, 8'h01);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, d); chk("R7 write 0 no effect", d, 8'h01);
    wr_reg(2'd3, 8'h01);
    rd_reg(2'd3, d); chk("R7 write 1 clears", d, 8'h00);
    idle(5);
    rd_reg(2'd3, d); chk("R6 persistent mismatch no reset", d, 8'h00);
    chk("R8 irq drops", {7'd0, irq}, 8'h00);
    restore();
  endtask

  task automatic t_compare();
    logic [7:0] d;
    wr_reg(2'd1, 8'hFE);
    idle(4);
    rd_reg(2'd3, d); chk("R9 cmp change mismatch", d, 8'h01);
    wr_reg(2'd3, 8'hFF);
    @(negedge clk); pins = 8'hFE;
    idle(8);
    rd_reg(2'd3, d); chk("R9 match raises nothing", d, 8'h00);
    @(negedge clk); pins = 8'hFF;
    idle(6);
    rd_reg(2'd3, d); chk("R9 high vs low ref", d, 8'h01);
    restore();
  endtask

  task automatic t_slow_filter();
    logic [7:0] d;
    wr_reg(2'd0, 8'h04);
    rd_reg(2'd0, d); chk("R2 ctl readback", d, 8'h04);
    @(negedge clk); pins = 8'hEE;
    ticks(1'b1, 128);
    @(negedge clk); pins = 8'hFF;
    ticks(1'b1, 300);
    rd_reg(2'd3, d); chk("R4 R5 glitch lo rejected hi none passes", d, 8'h10);
    wr_reg(2'd3, 8'hFF);
    @(negedge clk); pins = 8'hFE;
    ticks(1'b1, 260);
    rd_reg(2'd3, d); chk("R3 R4 slow128 accepted", d, 8'h01);
    restore();
  endtask

  task automatic t_fast_filter();
    logic [7:0] d;
    wr_reg(2'd0, 8'h30);
    @(negedge clk); pins = 8'hEF;
    ticks(1'b0, 4);
    @(negedge clk); pins = 8'hFF;
    ticks(1'b0, 20);
    rd_reg(2'd3, d); chk("R4 fast4 glitch rejected", d, 8'h00);
    @(negedge clk); pins = 8'hEF;
    ticks(1'b1, 40);
    rd_reg(2'd3, d); chk("R3 fast tap ignores slow ticks", d, 8'h00);
    ticks(1'b0, 10);
    rd_reg(2'd3, d); chk("R3 R4 fast4 accepted", d, 8'h10);
    restore();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_bypass_flag_irq();
    t_compare();
    t_slow_filter();
    t_fast_filter();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule